// File: doc/BRIEF.md
# Indirect Interrupt-Controller Register Front End

This block is the register front end of an interrupt controller. It decodes 32-bit reads and writes from a simple request bus. Only two locations are visible on that bus: an 8-bit index register and a 32-bit data window. Every internal register is reached by first writing its number into the index register and then reading or writing the window. The internal registers are a controller ID, a fixed version word that also reports how many table entries exist, an arbitration word that always reads zero, and a table of 64-bit redirection entries. Each entry is seen through the window as two 32-bit halves. An odd index selects the upper half and an even index selects the lower half.

The whole table is driven out in parallel to the interrupt service engine. The block also raises a one-cycle update pulse after every table write, so that the engine re-evaluates its pending pins. The request side always accepts, so `bus_ready` stays high and a requester is never held back. Each accepted read returns exactly one response on the following cycle. The response has no ready input, so the requester must be able to take it in that cycle. Interrupt delivery is not part of this block.

Top module: `ioxr_regfront`

## Requirements
- R1: Only the low 8 bits of `bus_addr` are decoded. Address 0x100 behaves exactly like 0x000, and 0x110 behaves exactly like 0x010.
- R2: Offset 0x00 is the index register. It is read/write, and its value sits in bits 7:0 of the data word. Offset 0x10 is the data window. A read of any other offset returns zero, and a write to any other offset changes nothing.
- R3: Window index 0x00 is the ID register. A write keeps only bits 27:24 of the data. A read returns the ID in bits 27:24, with every other bit zero.
- R4: Window index 0x01 is the version register and cannot be written. It reads as 0x11 in bits 7:0 and (NUM_ENT − 1) in bits 23:16. With 24 entries it reads 0x0017_0011.
- R5: Window index 0x02 reads as zero, and writes to it are ignored.
- R6: Window indices from 0x10 up select table entry (index − 0x10) >> 1. An even index reaches bits 31:0 and an odd index reaches bits 63:32. A write replaces only the selected half.
- R7: A window index that maps to no register reads zero and is ignored on write. This covers 0x03–0x0F and any index whose entry number is NUM_ENT or larger.
- R8: Reset clears the ID and the index register. It sets every table entry to 0x0000_0000_0001_0000, which is the mask bit (bit 16) alone.
- R9: `tbl_upd` is high for exactly the one cycle after each accepted table write. No other write raises it.
- R10: `tbl_flat[64*i +: 64]` always carries entry i. It changes only in the cycle after a table write.
- R11: An accepted read gives `rd_valid` high for exactly the next cycle, with `rd_data` valid in that cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_ready | output | 1 | Request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 7:0 are decoded |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid, one cycle after the read |
| rd_data | output | 32 | Read response data |
| tbl_flat | output | 64*NUM_ENT | All redirection entries, entry i at bits 64*i+63:64*i |
| tbl_upd | output | 1 | One-cycle pulse after a table write |

## Verification
On every cycle, the assertions check four things:
- the update pulse matches table writes one for one;
- the table output moves only after a window write;
- each response follows a read;
- the version, arbitration and ID reads return their fixed forms.

Only the bench scenarios can show the following:
- address aliasing;
- that a half write leaves the other half intact;
- the behaviour of out-of-range and undecoded indices;
- the reset contents of the table.

// File: rtl/ioxr_pkg.sv
package ioxr_pkg;
  localparam logic [7:0] OFS_SEL  = 8'h00;
  localparam logic [7:0] OFS_WIN  = 8'h10;
  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] IDX_TBL  = 8'h10;
  localparam logic [7:0] VER_CODE = 8'h11;
  localparam int ID_LSB    = 24;
  localparam int ID_W      = 4;
  localparam int MASK_BIT  = 16;
  localparam int CNT_LSB   = 16;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_ID, TGT_VER, TGT_ARB, TGT_TBL
  } tgt_e;

  typedef enum logic [1:0] {
    ACC_NONE, ACC_SEL, ACC_WIN
  } acc_e;
endpackage

// File: rtl/ioxr_decode.sv
module ioxr_decode
  import ioxr_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int ENT_W   = $clog2(NUM_ENT)
) (
  input  logic [7:0]       addr_lo,
  input  logic [7:0]       idx,
  output acc_e             acc,
  output tgt_e             tgt,
  output logic [ENT_W-1:0] ent,
  output logic             hi
);
  logic [7:0] off;
  logic [6:0] ent_full;

  always_comb begin
    if (addr_lo == OFS_SEL)      acc = ACC_SEL;
    else if (addr_lo == OFS_WIN) acc = ACC_WIN;
    else                         acc = ACC_NONE;
  end

  assign off      = idx - IDX_TBL;
  assign ent_full = off[7:1];
  assign hi       = idx[0];
  assign ent      = ent_full[ENT_W-1:0];

  always_comb begin
    if (idx == IDX_ID)        tgt = TGT_ID;
    else if (idx == IDX_VER)  tgt = TGT_VER;
    else if (idx == IDX_ARB)  tgt = TGT_ARB;
    else if (idx >= IDX_TBL && 32'(ent_full) < NUM_ENT) tgt = TGT_TBL;
    else                      tgt = TGT_NONE;
  end
endmodule

// File: rtl/ioxr_table.sv
module ioxr_table
  import ioxr_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int ENT_W   = $clog2(NUM_ENT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ENT_W-1:0]        wr_ent,
  input  logic                    wr_hi,
  input  logic [31:0]             wr_data,
  output logic [64*NUM_ENT-1:0]   tbl_flat
);
  localparam logic [63:0] RST_ENTRY = 64'(1) << MASK_BIT;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic [31:0] lo_q, hi_q;
    logic sel;
    assign sel = wr_en && (32'(wr_ent) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= RST_ENTRY[31:0];
        hi_q <= RST_ENTRY[63:32];
      end else if (sel) begin
        if (wr_hi) hi_q <= wr_data;
        else       lo_q <= wr_data;
      end
    end
    assign tbl_flat[64*g +: 64] = {hi_q, lo_q};
  end
endmodule

// File: rtl/ioxr_rdmux.sv
module ioxr_rdmux
  import ioxr_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int ENT_W   = $clog2(NUM_ENT)
) (
  input  acc_e                  acc,
  input  tgt_e                  tgt,
  input  logic [ENT_W-1:0]      ent,
  input  logic                  hi,
  input  logic [7:0]            idx,
  input  logic [ID_W-1:0]       id,
  input  logic [64*NUM_ENT-1:0] tbl_flat,
  output logic [31:0]           data
);
  localparam logic [7:0] LAST_ENT = 8'(NUM_ENT - 1);
  localparam logic [31:0] VER_WORD = {8'h00, LAST_ENT, 8'h00, VER_CODE};

  logic [63:0] entry;
  assign entry = tbl_flat[64*int'(ent) +: 64];

  always_comb begin
    data = '0;
    case (acc)
      ACC_SEL: data = {24'h0, idx};
      ACC_WIN: begin
        case (tgt)
          TGT_ID:  data[ID_LSB +: ID_W] = id;
          TGT_VER: data = VER_WORD;
          TGT_TBL: data = hi ? entry[63:32] : entry[31:0];
          default: data = '0;
        endcase
      end
      default: data = '0;
    endcase
  end
endmodule

// File: rtl/ioxr_regfront.sv
module ioxr_regfront
  import ioxr_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int ADDR_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  output logic                  bus_ready,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic                  rd_valid,
  output logic [31:0]           rd_data,
  output logic [64*NUM_ENT-1:0] tbl_flat,
  output logic                  tbl_upd
);
  localparam int ENT_W = $clog2(NUM_ENT);

  logic [7:0]       sel_idx;
  logic [ID_W-1:0]  id_q;
  acc_e             acc;
  tgt_e             tgt;
  logic [ENT_W-1:0] ent;
  logic             hi;
  logic [31:0]      rd_mux;
  logic             acc_rd, acc_wr, tbl_wr;

  assign bus_ready = 1'b1;
  assign acc_rd = bus_valid && !bus_write;
  assign acc_wr = bus_valid && bus_write;
  assign tbl_wr = acc_wr && (acc == ACC_WIN) && (tgt == TGT_TBL);

  ioxr_decode #(.NUM_ENT(NUM_ENT), .ENT_W(ENT_W)) u_dec (
    .addr_lo(bus_addr[7:0]), .idx(sel_idx),
    .acc(acc), .tgt(tgt), .ent(ent), .hi(hi)
  );

  ioxr_table #(.NUM_ENT(NUM_ENT), .ENT_W(ENT_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .wr_ent(ent),
    .wr_hi(hi), .wr_data(bus_wdata), .tbl_flat(tbl_flat)
  );

  ioxr_rdmux #(.NUM_ENT(NUM_ENT), .ENT_W(ENT_W)) u_mux (
    .acc(acc), .tgt(tgt), .ent(ent), .hi(hi), .idx(sel_idx),
    .id(id_q), .tbl_flat(tbl_flat), .data(rd_mux)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_idx  <= '0;
      id_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      tbl_upd  <= 1'b0;
    end else begin
      rd_valid <= acc_rd;
      if (acc_rd) rd_data <= rd_mux;
      tbl_upd  <= tbl_wr;
      if (acc_wr && acc == ACC_SEL) sel_idx <= bus_wdata[7:0];
      if (acc_wr && acc == ACC_WIN && tgt == TGT_ID)
        id_q <= bus_wdata[ID_LSB +: ID_W];
    end
  end
endmodule

// File: rtl/ioxr_regfront_chk.sv
module ioxr_regfront_chk #(
  parameter int NUM_ENT = 24,
  parameter int ADDR_W  = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_valid,
  input logic                  bus_write,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [7:0]            idx,
  input logic                  rd_valid,
  input logic [31:0]           rd_data,
  input logic [64*NUM_ENT-1:0] tbl_flat,
  input logic                  tbl_upd
);
  localparam logic [7:0]  TOP_IDX = 8'(16 + 2*NUM_ENT - 1);
  localparam logic [31:0] VER_EXP = {8'h00, 8'(NUM_ENT-1), 8'h00, 8'h11};

  logic win_acc, tbl_hit;
  assign win_acc = bus_valid && bus_addr[7:0] == 8'h10;
  assign tbl_hit = win_acc && bus_write && idx >= 8'h10 && idx <= TOP_IDX;

  // R9
  upd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_upd == $past(tbl_hit));

  // R10
  tbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_acc && bus_write) |-> $stable(tbl_flat));

  // R11
  rsp_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == $past(bus_valid && !bus_write));

  // R4
  ver_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(win_acc && idx == 8'h01)) |-> rd_data == VER_EXP);

  // R5
  arb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(win_acc && idx == 8'h02)) |-> rd_data == 32'h0);

  // R3
  id_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(win_acc && idx == 8'h00)) |-> (rd_data & 32'hF0FF_FFFF) == 32'h0);
endmodule

bind ioxr_regfront ioxr_regfront_chk #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .idx(sel_idx), .rd_valid(rd_valid), .rd_data(rd_data),
  .tbl_flat(tbl_flat), .tbl_upd(tbl_upd)
);

// File: tb/ioxr_regfront_tb.sv
`timescale 1ns/1ps
module ioxr_regfront_tb;
  localparam int N = 24;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, rd_valid, tbl_upd;
  logic [31:0] rd_data;
  logic [64*N-1:0] tbl_flat;

  int checks = 0, errors = 0;
  logic last_upd;
  logic [31:0] rv;

  always #4 clk = ~clk;

  ioxr_regfront #(.NUM_ENT(N), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .tbl_flat(tbl_flat), .tbl_upd(tbl_upd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    last_upd = tbl_upd;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); #1;
    chk("R11 rd_valid", 64'(rd_valid), 64'd1);
    d = rd_data;
    @(negedge clk);
    bus_valid = 0;
    @(posedge clk); #1;
    chk("R11 rd_valid drop", 64'(rd_valid), 64'd0);
  endtask

  task automatic win_rd(input logic [7:0] i, output logic [31:0] d);
    wr(12'h000, {24'h0, i});
    rd(12'h010, d);
  endtask

  task automatic t_reset();
    rd(12'h000, rv);        chk("R8 index reset", 64'(rv), 64'h0);
    win_rd(8'h00, rv);      chk("R8 id reset", 64'(rv), 64'h0);
    for (int i = 0; i < N; i++)
      chk("R8 entry reset", tbl_flat[64*i +: 64], 64'h0000_0000_0001_0000);
    win_rd(8'h10, rv);      chk("R8 entry0 lo", 64'(rv), 64'h0001_0000);
    chk("R9 upd idle", 64'(tbl_upd), 64'd0);
    chk("R2 bus_ready", 64'(bus_ready), 64'd1);
  endtask

  task automatic t_index();
    wr(12'h000, 32'hFFFF_FF35); rd(12'h000, rv);
    chk("R2 index rw", 64'(rv), 64'h35);
    wr(12'h100, 32'h0000_0021); rd(12'h000, rv);
    chk("R1 alias write", 64'(rv), 64'h21);
    rd(12'h100, rv);        chk("R1 alias read", 64'(rv), 64'h21);
    wr(12'h008, 32'h0000_0099); rd(12'h000, rv);
    chk("R2 undecoded write", 64'(rv), 64'h21);
    rd(12'h004, rv);        chk("R2 undecoded read", 64'(rv), 64'h0);
  endtask

  task automatic t_id();
    wr(12'h000, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF);
    chk("R9 no upd on id", 64'(last_upd), 64'd0);
    rd(12'h010, rv);        chk("R3 id masked", 64'(rv), 64'h0F00_0000);
    wr(12'h010, 32'h5A00_0000); rd(12'h110, rv);
    chk("R3 id value via R1 alias", 64'(rv), 64'h0A00_0000);
  endtask

  task automatic t_ver_arb();
    win_rd(8'h01, rv);      chk("R4 version", 64'(rv), 64'h0017_0011);
    wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, rv);
    chk("R4 version ro", 64'(rv), 64'h0017_0011);
    wr(12'h000, 32'h02); wr(12'h010, 32'hDEAD_BEEF); rd(12'h010, rv);
    chk("R5 arb zero", 64'(rv), 64'h0);
  endtask

  task automatic t_table();
    wr(12'h000, 32'h10); wr(12'h010, 32'hA5A5_0033);
    chk("R9 upd lo", 64'(last_upd), 64'd1);
    @(posedge clk); #1;
    chk("R9 upd one cycle", 64'(tbl_upd), 64'd0);
    rd(12'h010, rv);        chk("R6 lo read", 64'(rv), 64'hA5A5_0033);
    wr(12'h000, 32'h11); wr(12'h010, 32'h1234_5678);
    chk("R9 upd hi", 64'(last_upd), 64'd1);
    rd(12'h010, rv);        chk("R6 hi read", 64'(rv), 64'h1234_5678);
    chk("R10 entry0 out", tbl_flat[63:0], 64'h1234_5678_A5A5_0033);
    chk("R10 entry1 untouched", tbl_flat[127:64], 64'h0000_0000_0001_0000);
    wr(12'h000, 32'h3F); wr(12'h010, 32'hCAFE_0001);
    chk("R6 last hi", tbl_flat[64*(N-1) +: 64], 64'hCAFE_0001_0001_0000);
    wr(12'h000, 32'h2C); wr(12'h010, 32'h0000_00C7);
    chk("R6 entry14 lo", tbl_flat[64*14 +: 64], 64'h0000_0000_0000_00C7);
  endtask

  task automatic t_range();
    logic [64*N-1:0] snap;
    snap = tbl_flat;
    wr(12'h000, 32'h40); wr(12'h010, 32'hFFFF_FFFF);
    chk("R7 no upd out of range", 64'(last_upd), 64'd0);
    rd(12'h010, rv);        chk("R7 read zero", 64'(rv), 64'h0);
    wr(12'h000, 32'h05); wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, rv);        chk("R7 gap index zero", 64'(rv), 64'h0);
    checks++;
    if (tbl_flat !== snap) begin
      errors++;
      $display("FAIL R7 table changed actual=%h expected=%h", tbl_flat[127:0], snap[127:0]);
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_index();
    t_id();
    t_ver_arb();
    t_table();
    t_range();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule